// File: doc/BRIEF.md
# PCI Base Address Register Bank

This block holds a small set of base address registers for a PCI-style target. Each register claims one address window. The window's size, its address space (memory or I/O), its placement code and its prefetch flag are not fixed when the design is built. They come at run time from a per-window map input.

System software finds the size of a window in two steps. First it writes all ones to the register. Then it reads the register back. The address bits below the window size cannot be written and read as zero, so the lowest set address bit shows the size. The low four bits of the read value always carry the window's attributes.

A window that is switched off in its map reads as all zeros and ignores writes. An incoming bus address and its space flag are compared against every enabled window, and each window has its own hit output.

Top module: `pci_bar_bank`

## Requirements
- R1: After reset every stored base address is zero, so an enabled window reads back only its four attribute bits.
- R2: After an all-ones write, the read value has ones in every address bit from the size boundary up to bit 31 and zeros from bit 4 up to the boundary. For example, a 4 MB (size code 22) prefetchable 32-bit memory window reads FFC0_0008h.
- R3: Read bit 0 equals the window's space setting: 0 means memory, 1 means I/O.
- R4: Read bits 2:1 equal the window's 2-bit placement code: 00 means anywhere in 32-bit space, 01 means below 1 MB, 10 means anywhere in 64-bit space, 11 is reserved.
- R5: Read bit 3 equals the window's prefetch flag, where 1 means prefetching is allowed.
- R6: The map size code s is log2 of the window size in bytes, and codes below 4 act as 4. Address bits below bit s always read zero and keep no written value. For example, code 23 (8 MB) reads back with bit 23 as its lowest set bit.
- R7: A write changes only the bytes whose enable bit is set, where enable bit k covers data bits 8k+7:8k.
- R8: A window whose map enable is 0 reads as 0000_0000h. A write to it leaves its stored base unchanged, which shows once the window is enabled again.
- R9: The hit output for a window is 1 only when the window is enabled, the bus space flag equals the window's space setting, and bus address bits s and above equal the stored base bits.
- R10: When the size code grows, the read value masks the new low bits at once. The stored bits below the new boundary are cleared at the next clock edge, so they stay zero even after the size code shrinks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Selected window for a read or write |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read value of the selected window (combinational) |
| map_en | input | NUM_AP | Per-window enable |
| map_size | input | NUM_AP*5 | Per-window size code, log2 of bytes |
| map_io | input | NUM_AP | Per-window space: 1 means I/O |
| map_pref | input | NUM_AP | Per-window prefetch flag |
| map_loc | input | NUM_AP*2 | Per-window placement code |
| bus_addr | input | 32 | Incoming access address |
| bus_io | input | 1 | Incoming access is in I/O space |
| hit | output | NUM_AP | Per-window address match |

## Verification
The read value and the hit vector are combinational. They follow cfg_sel, the map inputs and the bus address in the same cycle, and a write shows in them from the first clock edge after it. The bench drives every input just after a falling edge, lets a write pass one rising edge, and samples a short delay after the next falling edge, so no check lands on an edge. The size-growth case is checked twice: once before the following edge, where only the read mask applies, and once after it, where the stored bits have been cleared.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;
  localparam int ADDR_W   = 32;
  localparam int SIZE_W   = 5;
  localparam int BE_W     = ADDR_W / 8;
  localparam int ATTR_W   = 4;
  localparam int MIN_SIZE = 4;

  // Ones from the size boundary upward; codes below MIN_SIZE act as MIN_SIZE.
  function automatic logic [ADDR_W-1:0] size_mask(input logic [SIZE_W-1:0] code);
    logic [SIZE_W-1:0] eff;
    eff = (code < SIZE_W'(MIN_SIZE)) ? SIZE_W'(MIN_SIZE) : code;
    return ~((ADDR_W'(1) << eff) - ADDR_W'(1));
  endfunction

  // Byte-wise merge of write data into an old word.
  function automatic logic [ADDR_W-1:0] be_merge(input logic [ADDR_W-1:0] old_w,
                                                 input logic [ADDR_W-1:0] new_w,
                                                 input logic [BE_W-1:0]   be);
    logic [ADDR_W-1:0] res;
    res = old_w;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) res[b*8 +: 8] = new_w[b*8 +: 8];
    return res;
  endfunction
endpackage

// File: rtl/bar_slot.sv
module bar_slot
  import pci_bar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   be,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              map_en,
  input  logic [SIZE_W-1:0] map_size,
  input  logic              map_io,
  input  logic              map_pref,
  input  logic [1:0]        map_loc,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_io,
  output logic [ADDR_W-1:0] rd_val,
  output logic              hit,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] mask_o,
  output logic              wr_fire
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;
  logic [ADDR_W-1:0] mask;
  logic [ATTR_W-1:0] attr;

  assign mask    = size_mask(map_size);
  assign attr    = {map_pref, map_loc, map_io};
  assign wr_fire = wr_en & map_en;
  assign base_d  = wr_fire ? be_merge(base_q, wdata, be) : base_q;

  // Masking on every edge clears bits that fall below a grown boundary.
  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d & mask;
  end

  assign rd_val = map_en ? ((base_q & mask) | ADDR_W'(attr)) : '0;
  assign hit    = map_en && (bus_io == map_io) &&
                  ((bus_addr & mask) == (base_q & mask));
  assign base_o = base_q;
  assign mask_o = mask;
endmodule

// File: rtl/bar_rdmux.sv
module bar_rdmux
  import pci_bar_pkg::*;
#(
  parameter int NUM_AP = 4,
  parameter int SEL_W  = 2
) (
  input  logic [NUM_AP*ADDR_W-1:0] rd_flat,
  input  logic [SEL_W-1:0]         sel,
  output logic [ADDR_W-1:0]        rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_AP; i++)
      if (sel == SEL_W'(i)) rdata = rd_flat[i*ADDR_W +: ADDR_W];
  end
endmodule

// File: rtl/pci_bar_bank.sv
module pci_bar_bank
  import pci_bar_pkg::*;
#(
  parameter int NUM_AP = 4,
  localparam int SEL_W = (NUM_AP > 1) ? $clog2(NUM_AP) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic [3:0]               cfg_be,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  input  logic [NUM_AP-1:0]        map_en,
  input  logic [NUM_AP*5-1:0]      map_size,
  input  logic [NUM_AP-1:0]        map_io,
  input  logic [NUM_AP-1:0]        map_pref,
  input  logic [NUM_AP*2-1:0]      map_loc,
  input  logic [31:0]              bus_addr,
  input  logic                     bus_io,
  output logic [NUM_AP-1:0]        hit
);
  logic [NUM_AP*ADDR_W-1:0] rd_flat;
  logic [NUM_AP*ADDR_W-1:0] base_flat;
  logic [NUM_AP*ADDR_W-1:0] mask_flat;
  logic [NUM_AP-1:0]        wr_fire;

  for (genvar i = 0; i < NUM_AP; i++) begin : g_slot
    bar_slot slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_sel == SEL_W'(i))),
      .be       (cfg_be),
      .wdata    (cfg_wdata),
      .map_en   (map_en[i]),
      .map_size (map_size[i*SIZE_W +: SIZE_W]),
      .map_io   (map_io[i]),
      .map_pref (map_pref[i]),
      .map_loc  (map_loc[i*2 +: 2]),
      .bus_addr (bus_addr),
      .bus_io   (bus_io),
      .rd_val   (rd_flat[i*ADDR_W +: ADDR_W]),
      .hit      (hit[i]),
      .base_o   (base_flat[i*ADDR_W +: ADDR_W]),
      .mask_o   (mask_flat[i*ADDR_W +: ADDR_W]),
      .wr_fire  (wr_fire[i])
    );
  end

  bar_rdmux #(.NUM_AP(NUM_AP), .SEL_W(SEL_W)) rdmux_i (
    .rd_flat (rd_flat),
    .sel     (cfg_sel),
    .rdata   (cfg_rdata)
  );
endmodule

// File: rtl/pci_bar_bank_chk.sv
module pci_bar_bank_chk #(
  parameter int NUM_AP = 4,
  parameter int SEL_W  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [SEL_W-1:0]     cfg_sel,
  input logic [31:0]          cfg_rdata,
  input logic [NUM_AP-1:0]    map_en,
  input logic [NUM_AP*5-1:0]  map_size,
  input logic [NUM_AP-1:0]    map_io,
  input logic [NUM_AP-1:0]    map_pref,
  input logic [NUM_AP*2-1:0]  map_loc,
  input logic [NUM_AP-1:0]    hit,
  input logic [NUM_AP*32-1:0] base_flat,
  input logic [NUM_AP*32-1:0] mask_flat,
  input logic [NUM_AP-1:0]    wr_fire
);
  assert_disabled_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !map_en[cfg_sel] |-> cfg_rdata == 32'd0);

  assert_attr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    map_en[cfg_sel] |-> cfg_rdata[3:0] ==
      {map_pref[cfg_sel], map_loc[cfg_sel*2 +: 2], map_io[cfg_sel]});

  assert_low_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~mask_flat[cfg_sel*32 +: 32] & 32'hFFFF_FFF0) == 32'd0);

  assert_hit_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & ~map_en) == '0);

  for (genvar i = 0; i < NUM_AP; i++) begin : g_ap
    assert_base_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_fire[i] && $stable(map_size[i*5 +: 5])) |=> $stable(base_flat[i*32 +: 32]));

    assert_stored_below_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(map_size[i*5 +: 5]) |->
        (base_flat[i*32 +: 32] & ~mask_flat[i*32 +: 32]) == 32'd0);
  end
endmodule

bind pci_bar_bank pci_bar_bank_chk #(.NUM_AP(NUM_AP), .SEL_W(SEL_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_sel   (cfg_sel),
  .cfg_rdata (cfg_rdata),
  .map_en    (map_en),
  .map_size  (map_size),
  .map_io    (map_io),
  .map_pref  (map_pref),
  .map_loc   (map_loc),
  .hit       (hit),
  .base_flat (base_flat),
  .mask_flat (mask_flat),
  .wr_fire   (wr_fire)
);

// File: tb/pci_bar_bank_tb_top.sv
module pci_bar_bank_tb_top;
  localparam int CLK_P = 10;
  localparam int NAP   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_sel = '0;
  logic [3:0]      cfg_be = '0;
  logic [31:0]     cfg_wdata = '0;
  logic [31:0]     cfg_rdata;
  logic [NAP-1:0]  map_en = '0;
  logic [NAP*5-1:0] map_size = '0;
  logic [NAP-1:0]  map_io = '0;
  logic [NAP-1:0]  map_pref = '0;
  logic [NAP*2-1:0] map_loc = '0;
  logic [31:0]     bus_addr = '0;
  logic            bus_io = 1'b0;
  logic [NAP-1:0]  hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pci_bar_bank #(.NUM_AP(NAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .map_en(map_en), .map_size(map_size),
    .map_io(map_io), .map_pref(map_pref), .map_loc(map_loc), .bus_addr(bus_addr),
    .bus_io(bus_io), .hit(hit)
  );

  // Expected read value, built by shifting rather than by subtraction.
  function automatic logic [31:0] exp_rd(input bit en, input int sz, input logic [31:0] base,
                                         input bit io, input bit pref, input logic [1:0] loc);
    int e;
    logic [31:0] m;
    if (!en) return 32'd0;
    e = (sz < 4) ? 4 : sz;
    m = 32'hFFFF_FFFF << e;
    return (base & m) | {28'd0, pref, loc, io};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_map(input int i, input bit en, input int sz, input bit io,
                         input bit pref, input logic [1:0] loc);
    map_en[i] = en;
    map_size[i*5 +: 5] = 5'(sz);
    map_io[i] = io;
    map_pref[i] = pref;
    map_loc[i*2 +: 2] = loc;
  endtask

  task automatic wr(input int i, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_sel = 2'(i); cfg_be = be; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input int i, input string req, input logic [31:0] exp);
    cfg_sel = 2'(i);
    #1;
    check(req, cfg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NAP; i++) set_map(i, 1'b1, 12, i[0], i[1], 2'(i));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: stored bases are zero after reset
    for (int i = 0; i < NAP; i++)
      rd_check(i, "R1", exp_rd(1, 12, 32'd0, i[0], i[1], 2'(i)));

    // R2 R3 R4 R5 R6: all-ones sizing sweep over every size code and attribute pattern
    for (int sz = 0; sz < 32; sz++) begin
      @(negedge clk);
      set_map(0, 1'b1, sz, sz[0], sz[1], 2'(sz >> 2));
      wr(0, 4'hF, 32'hFFFF_FFFF);
      rd_check(0, "R2/R3/R4/R5/R6 sizing", exp_rd(1, sz, 32'hFFFF_FFFF, sz[0], sz[1], 2'(sz >> 2)));
    end

    // R2: 4 MB prefetchable 32-bit memory window
    @(negedge clk);
    set_map(0, 1'b1, 22, 1'b0, 1'b1, 2'b00);
    wr(0, 4'hF, 32'hFFFF_FFFF);
    rd_check(0, "R2 4MB", 32'hFFC0_0008);
    // R6: 8 MB window, lowest set address bit is 23
    @(negedge clk);
    set_map(0, 1'b1, 23, 1'b0, 1'b0, 2'b00);
    wr(0, 4'hF, 32'hFFFF_FFFF);
    rd_check(0, "R6 8MB", 32'hFF80_0000);
    // R4: reserved and 64-bit placement codes pass through
    @(negedge clk);
    set_map(0, 1'b1, 23, 1'b0, 1'b0, 2'b11);
    rd_check(0, "R4 code 11", 32'hFF80_0006);

    // R7: byte enables
    @(negedge clk);
    set_map(0, 1'b1, 4, 1'b0, 1'b0, 2'b00);
    wr(0, 4'hF, 32'h0000_0000);
    wr(0, 4'b0101, 32'hAABB_CCDD);
    rd_check(0, "R7 be=0101", 32'h00BB_00D0);
    wr(0, 4'b1000, 32'h1122_3344);
    rd_check(0, "R7 be=1000", 32'h11BB_00D0);

    // R8: disabled window reads zero and ignores writes
    @(negedge clk);
    set_map(1, 1'b0, 4, 1'b0, 1'b0, 2'b00);
    wr(1, 4'hF, 32'hFFFF_FFFF);
    rd_check(1, "R8 disabled read", 32'd0);
    @(negedge clk);
    map_en[1] = 1'b1;
    rd_check(1, "R8 write ignored", 32'd0);

    // R10: size growth masks at once, stored bits cleared at the next edge
    @(negedge clk);
    set_map(2, 1'b1, 16, 1'b0, 1'b0, 2'b00);
    wr(2, 4'hF, 32'hFFFF_FFFF);
    rd_check(2, "R10 before", 32'hFFFF_0000);
    @(negedge clk);
    map_size[2*5 +: 5] = 5'd24;
    rd_check(2, "R10 same cycle", 32'hFF00_0000);
    @(negedge clk);
    map_size[2*5 +: 5] = 5'd16;
    rd_check(2, "R10 after shrink", 32'hFF00_0000);

    // R9: hit sweep, flipping one address bit at a time
    @(negedge clk);
    set_map(3, 1'b1, 20, 1'b0, 1'b0, 2'b00);
    wr(3, 4'hF, 32'h1230_0000);
    rd_check(3, "R9 base", 32'h1230_0000);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      bus_io = 1'b0;
      bus_addr = 32'h1230_0000 ^ (32'd1 << k);
      #1;
      check("R9 addr flip", {31'd0, hit[3]}, {31'd0, k < 20});
    end
    @(negedge clk);
    bus_addr = 32'h123F_FFFC; bus_io = 1'b1;
    #1; check("R9 space mismatch", {31'd0, hit[3]}, 32'd0);
    @(negedge clk);
    bus_io = 1'b0;
    #1; check("R9 match", {31'd0, hit[3]}, 32'd1);
    @(negedge clk);
    map_en[3] = 1'b0;
    #1; check("R9 disabled", {31'd0, hit[3]}, 32'd0);
    @(negedge clk);
    set_map(3, 1'b1, 20, 1'b1, 1'b0, 2'b00);
    bus_io = 1'b1;
    #1; check("R9 io window", {31'd0, hit[3]}, 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule